// File: doc/BRIEF.md
# Output Test Pattern Selector

This block sits between a converter's sample path and its serializer. On each frame it either forwards the live sample or puts a test word in its place. The test word comes from one of twelve selectable patterns. There are fixed level codes, alternating two-word sequences, words built from four 8-bit user registers, and the words of two external pseudorandom generators. Receiver bring-up logic uses these patterns to prove capture and bit alignment without an analog input.

The output word is registered and changes only on a frame strobe. Length-aware patterns are right-aligned to the selected word length of 8 to 14 bits. A companion flag tells the downstream data-format stage whether this frame's word may be converted. A strap pin is sampled during reset. When it was high, every frame carries the fixed alignment word 10_0000_0000, whatever the mode register says.

Top module: `tpat_select`

## Requirements
- R1: Mode codes 0, 13, 14 and 15 forward `sample_in` unchanged to `word_out`, with `fmt_apply` = 1.
- R2: Mode 1 gives midscale (only bit L-1 set). Mode 2 gives positive full scale (the low L bits all ones). Mode 3 gives negative full scale (all zeros). These three set `fmt_apply` = 1.
- R3: Mode 10 gives all zeros and mode 11 gives the low L bits all ones. Mode 12 gives a sync word: bits L-1 down to floor(L/2) are ones and the lower bits are zeros. Every mode from 4 to 12 clears `fmt_apply`.
- R4: Two user words are formed: word A = {reg1, reg0} and word B = {reg3, reg2}, each 16 bits. The output is the upper L bits of the word, right-aligned. Mode 8 repeats word A. Mode 9 alternates A, B, A, ...
- R5: Mode 5 outputs `pn_long_in` and mode 6 outputs `pn_short_in`, unchanged and with no length trimming.
- R6: The effective length L is `word_len` clamped to the range 8 to 14. Length-aware patterns occupy bits L-1..0, with bit L-1 as the first-sent MSB. Bits above L-1 are zero.
- R7: Mode 4 alternates two checkerboard words: first the word with even-numbered bits set, then its complement within L bits. Mode 7 alternates all-ones (L bits) and all-zeros.
- R8: When the frame on which a new mode code is first seen, a two-word pattern starts with its first word. After that the pattern advances one word per frame strobe and never between strobes.
- R9: `word_out`, `fmt_apply` and `word_vld` change only on the clock edge that samples `frame_en` = 1. At that edge `word_vld` goes to 1, and it returns to 0 on the next edge unless another strobe is sampled.
- R10: The strap level is the value of `strap_in` in the last reset cycle and is frozen after reset. While it is 1, each frame outputs 0x200 with `fmt_apply` = 0 in every mode.
- R11: Synchronous reset clears `word_out`, `fmt_apply` and `word_vld` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| frame_en | input | 1 | One-cycle strobe per output frame |
| mode_sel | input | 4 | Pattern mode code |
| word_len | input | LW (4) | Requested word length in bits |
| sample_in | input | W (14) | Live converter sample |
| user_reg0 | input | 8 | Low byte of user word A |
| user_reg1 | input | 8 | High byte of user word A |
| user_reg2 | input | 8 | Low byte of user word B |
| user_reg3 | input | 8 | High byte of user word B |
| pn_long_in | input | W (14) | Current word of the long pseudorandom generator |
| pn_short_in | input | W (14) | Current word of the short pseudorandom generator |
| strap_in | input | 1 | Strap pin forcing the alignment word |
| word_out | output | W (14) | Registered output word |
| fmt_apply | output | 1 | Data-format conversion applies to this word |
| word_vld | output | 1 | Pulses one cycle after each sampled frame strobe |

## Verification
A wrong alternation phase shows up as the second word of a two-word pattern in the first frame after a mode change. It is visible on `word_out` one cycle after that frame strobe. A wrong length clamp or mask puts a stray bit above L-1 or drops the MSB, and this shows in the very next output word. A strap latch that follows the pin after reset replaces the alignment word with the mode's pattern on the first frame after the pin moves.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

  localparam int MIN_LEN   = 8;
  localparam int USER_BITS = 16;
  localparam logic [9:0] ALIGN_WORD = 10'h200;

  typedef enum logic [3:0] {
    MD_PASS   = 4'd0,
    MD_MID    = 4'd1,
    MD_PFS    = 4'd2,
    MD_NFS    = 4'd3,
    MD_CHECK  = 4'd4,
    MD_PNL    = 4'd5,
    MD_PNS    = 4'd6,
    MD_TOGGLE = 4'd7,
    MD_USER1  = 4'd8,
    MD_USER2  = 4'd9,
    MD_ZERO   = 4'd10,
    MD_ONE    = 4'd11,
    MD_SYNC   = 4'd12
  } mode_e;

  function automatic logic len_aware(input logic [3:0] m);
    return (m >= 4'd1) && (m <= 4'd12) && (m != 4'd5) && (m != 4'd6);
  endfunction

endpackage

// File: rtl/tpat_len_mask.sv
module tpat_len_mask #(
  parameter int W  = 14,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [LW-1:0] req_len,
  output logic [LW-1:0] eff_len,
  output logic [W-1:0]  len_mask
);
  import tpat_pkg::*;

  localparam logic [LW-1:0] LO = LW'(MIN_LEN);
  localparam logic [LW-1:0] HI = LW'(W);

  always_comb begin
    if (req_len < LO)      eff_len = LO;
    else if (req_len > HI) eff_len = HI;
    else                   eff_len = req_len;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_mask
      assign len_mask[i] = (LW'(i) < eff_len);
    end
  endgenerate

endmodule

// File: rtl/tpat_alt_seq.sv
module tpat_alt_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_en,
  input  logic [3:0] mode_sel,
  output logic       use_second
);

  logic [3:0] mode_q;
  logic       phase_q;
  logic       changed;

  assign changed    = (mode_sel != mode_q);
  assign use_second = changed ? 1'b0 : phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      phase_q <= 1'b0;
    end else if (frame_en) begin
      mode_q  <= mode_sel;
      phase_q <= ~use_second;
    end
  end

  AST_ALT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (frame_en && changed) |=> phase_q) else $error("alternation restart");  // R8
  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_en |=> $stable(phase_q)) else $error("phase moved between frames");  // R8

endmodule

// File: rtl/tpat_word_gen.sv
module tpat_word_gen #(
  parameter int W  = 14,
  parameter int LW = $clog2(W + 1)
) (
  input  logic [3:0]    mode_sel,
  input  logic          use_second,
  input  logic [LW-1:0] eff_len,
  input  logic [W-1:0]  len_mask,
  input  logic [W-1:0]  sample_in,
  input  logic [15:0]   user_a,
  input  logic [15:0]   user_b,
  input  logic [W-1:0]  pn_long_in,
  input  logic [W-1:0]  pn_short_in,
  output logic [W-1:0]  gen_word,
  output logic          gen_fmt
);
  import tpat_pkg::*;

  logic [W-1:0] mid_w, even_w, sync_w, user_w;
  logic [15:0]  user_sel;

  assign user_sel = (mode_sel == MD_USER2 && use_second) ? user_b : user_a;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      mid_w[i]  = (LW'(i) == eff_len - LW'(1));
      even_w[i] = len_mask[i] & ((i % 2) == 0);
      sync_w[i] = len_mask[i] & (LW'(i) >= (eff_len >> 1));
      user_w[i] = 1'b0;
      if (USER_BITS - int'(eff_len) + i < USER_BITS)
        user_w[i] = len_mask[i] & user_sel[USER_BITS - int'(eff_len) + i];
    end
  end

  always_comb begin
    gen_fmt  = 1'b0;
    gen_word = '0;
    case (mode_sel)
      MD_MID:    begin gen_word = mid_w;    gen_fmt = 1'b1; end
      MD_PFS:    begin gen_word = len_mask; gen_fmt = 1'b1; end
      MD_NFS:    begin gen_word = '0;       gen_fmt = 1'b1; end
      MD_CHECK:  gen_word = use_second ? (len_mask & ~even_w) : even_w;
      MD_PNL:    gen_word = pn_long_in;
      MD_PNS:    gen_word = pn_short_in;
      MD_TOGGLE: gen_word = use_second ? '0 : len_mask;
      MD_USER1,
      MD_USER2:  gen_word = user_w;
      MD_ZERO:   gen_word = '0;
      MD_ONE:    gen_word = len_mask;
      MD_SYNC:   gen_word = sync_w;
      default:   begin gen_word = sample_in; gen_fmt = 1'b1; end
    endcase
  end

endmodule

// File: rtl/tpat_select.sv
module tpat_select #(
  parameter int W  = 14,
  parameter int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_en,
  input  logic [3:0]    mode_sel,
  input  logic [LW-1:0] word_len,
  input  logic [W-1:0]  sample_in,
  input  logic [7:0]    user_reg0,
  input  logic [7:0]    user_reg1,
  input  logic [7:0]    user_reg2,
  input  logic [7:0]    user_reg3,
  input  logic [W-1:0]  pn_long_in,
  input  logic [W-1:0]  pn_short_in,
  input  logic          strap_in,
  output logic [W-1:0]  word_out,
  output logic          fmt_apply,
  output logic          word_vld
);
  import tpat_pkg::*;

  localparam logic [W-1:0] STRAP_WORD = W'(ALIGN_WORD);

  logic [LW-1:0] eff_len;
  logic [W-1:0]  len_mask;
  logic          use_second;
  logic [W-1:0]  gen_word;
  logic          gen_fmt;
  logic          strap_q;

  tpat_len_mask #(.W(W), .LW(LW)) i_len (
    .req_len (word_len),
    .eff_len (eff_len),
    .len_mask(len_mask)
  );

  tpat_alt_seq i_seq (
    .clk       (clk),
    .rst       (rst),
    .frame_en  (frame_en),
    .mode_sel  (mode_sel),
    .use_second(use_second)
  );

  tpat_word_gen #(.W(W), .LW(LW)) i_gen (
    .mode_sel   (mode_sel),
    .use_second (use_second),
    .eff_len    (eff_len),
    .len_mask   (len_mask),
    .sample_in  (sample_in),
    .user_a     ({user_reg1, user_reg0}),
    .user_b     ({user_reg3, user_reg2}),
    .pn_long_in (pn_long_in),
    .pn_short_in(pn_short_in),
    .gen_word   (gen_word),
    .gen_fmt    (gen_fmt)
  );

  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out  <= '0;
      fmt_apply <= 1'b0;
      word_vld  <= 1'b0;
    end else begin
      word_vld <= frame_en;
      if (frame_en) begin
        word_out  <= strap_q ? STRAP_WORD : gen_word;
        fmt_apply <= strap_q ? 1'b0 : gen_fmt;
      end
    end
  end

  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_en) |-> ($stable(word_out) && $stable(fmt_apply))) else $error("output moved");  // R9
  AST_VLD_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_en |=> word_vld) else $error("valid missing");  // R9
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(strap_q)) else $error("strap moved");  // R10
  AST_STRAP_WORD: assert property (@(posedge clk) disable iff (rst)
    (strap_q && word_vld) |-> (word_out == STRAP_WORD && !fmt_apply)) else $error("strap word");  // R10
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (eff_len >= LW'(MIN_LEN)) && (eff_len <= LW'(W))) else $error("length clamp");  // R6
  AST_PATTERN_MASKED: assert property (@(posedge clk) disable iff (rst)
    len_aware(mode_sel) |-> ((gen_word & ~len_mask) == '0)) else $error("bits above length");  // R6

endmodule

// File: tb/test_tpat_select.sv
module test_tpat_select;

  localparam int W  = 14;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_en = 1'b0;
  logic [3:0]    mode_sel = '0;
  logic [LW-1:0] word_len = 4'd10;
  logic [W-1:0]  sample_in = '0;
  logic [7:0]    user_reg0 = 8'h5A, user_reg1 = 8'hC3, user_reg2 = 8'h34, user_reg3 = 8'h12;
  logic [W-1:0]  pn_long_in = 14'h2A5C, pn_short_in = 14'h1DF9;
  logic          strap_in = 1'b0;
  logic [W-1:0]  word_out;
  logic          fmt_apply, word_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  tpat_select #(.W(W), .LW(LW)) i_tpat_select (
    .clk(clk), .rst(rst), .frame_en(frame_en), .mode_sel(mode_sel),
    .word_len(word_len), .sample_in(sample_in),
    .user_reg0(user_reg0), .user_reg1(user_reg1), .user_reg2(user_reg2), .user_reg3(user_reg3),
    .pn_long_in(pn_long_in), .pn_short_in(pn_short_in), .strap_in(strap_in),
    .word_out(word_out), .fmt_apply(fmt_apply), .word_vld(word_vld)
  );

  // {mode, len, sample, expected word, expected fmt}
  localparam int NV = 17;
  localparam logic [36:0] VEC [NV] = '{
    {4'd0,  4'd10, 14'h02AB, 14'h02AB, 1'b1},  // R1
    {4'd1,  4'd10, 14'h1111, 14'h0200, 1'b1},  // R2
    {4'd2,  4'd12, 14'h1111, 14'h0FFF, 1'b1},  // R2
    {4'd3,  4'd14, 14'h1111, 14'h0000, 1'b1},  // R2
    {4'd4,  4'd8,  14'h1111, 14'h0055, 1'b0},  // R7
    {4'd7,  4'd9,  14'h1111, 14'h01FF, 1'b0},  // R7
    {4'd8,  4'd12, 14'h1111, 14'h0C35, 1'b0},  // R4
    {4'd8,  4'd8,  14'h1111, 14'h00C3, 1'b0},  // R4
    {4'd10, 4'd14, 14'h1111, 14'h0000, 1'b0},  // R3
    {4'd11, 4'd11, 14'h1111, 14'h07FF, 1'b0},  // R3
    {4'd12, 4'd10, 14'h1111, 14'h03E0, 1'b0},  // R3
    {4'd12, 4'd13, 14'h1111, 14'h1FC0, 1'b0},  // R3
    {4'd5,  4'd8,  14'h1111, 14'h2A5C, 1'b0},  // R5
    {4'd6,  4'd9,  14'h1111, 14'h1DF9, 1'b0},  // R5
    {4'd15, 4'd10, 14'h3123, 14'h3123, 1'b1},  // R1
    {4'd1,  4'd5,  14'h1111, 14'h0080, 1'b1},  // R6
    {4'd1,  4'd15, 14'h1111, 14'h2000, 1'b1}   // R6
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one frame strobe; returns at the negedge after the capturing edge
  task automatic frame(input logic [3:0] m, input logic [LW-1:0] l, input logic [W-1:0] s);
    @(negedge clk);
    mode_sel = m; word_len = l; sample_in = s; frame_en = 1'b1;
    @(negedge clk);
    frame_en = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; strap_in = strap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    check("R11 reset word", word_out, '0);
    check("R11 reset fmt", W'(fmt_apply), '0);
    check("R11 reset vld", W'(word_vld), '0);

    for (int k = 0; k < NV; k++) begin
      frame(VEC[k][36:33], VEC[k][32:29], VEC[k][28:15]);
      check($sformatf("vector %0d word", k), word_out, VEC[k][14:1]);
      check($sformatf("vector %0d fmt", k), W'(fmt_apply), W'(VEC[k][0]));
    end

    // R9: valid pulse and hold between strobes
    frame(4'd11, 4'd10, '0);
    check("R9 vld high", W'(word_vld), W'(1));
    mode_sel = 4'd10; sample_in = 14'h3FFF;
    @(negedge clk);
    check("R9 vld low", W'(word_vld), '0);
    repeat (3) @(negedge clk);
    check("R9 held word", word_out, 14'h03FF);

    // R4 / R8: user alternation
    frame(4'd9, 4'd12, '0); check("R4 user A", word_out, 14'h0C35);
    frame(4'd9, 4'd12, '0); check("R4 user B", word_out, 14'h0123);
    frame(4'd9, 4'd12, '0); check("R4 user A again", word_out, 14'h0C35);
    // R7 checkerboard alternation
    frame(4'd4, 4'd10, '0); check("R7 checker first", word_out, 14'h0155);
    frame(4'd4, 4'd10, '0); check("R7 checker second", word_out, 14'h02AA);
    frame(4'd7, 4'd10, '0); check("R8 restart toggle ones", word_out, 14'h03FF);
    frame(4'd7, 4'd10, '0); check("R7 toggle zeros", word_out, 14'h0000);
    // R8: idle gap does not advance
    repeat (4) @(negedge clk);
    frame(4'd7, 4'd10, '0); check("R8 no advance in gap", word_out, 14'h03FF);
    frame(4'd9, 4'd12, '0); check("R8 mode change word A", word_out, 14'h0C35);
    frame(4'd8, 4'd12, '0);
    frame(4'd9, 4'd12, '0); check("R8 back to word A", word_out, 14'h0C35);

    // R10: strap forces alignment word, frozen after reset
    do_reset(1'b1);
    @(negedge clk);
    strap_in = 1'b0;
    frame(4'd11, 4'd14, '0);
    check("R10 strap word", word_out, 14'h0200);
    check("R10 strap fmt", W'(fmt_apply), '0);
    frame(4'd0, 4'd10, 14'h0033);
    check("R10 strap over pass", word_out, 14'h0200);
    do_reset(1'b0);
    frame(4'd0, 4'd10, 14'h0033);
    check("R10 strap cleared", word_out, 14'h0033);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule